// File: doc/BRIEF.md
# Audio Transmit Slot Channel

This block is one outbound sample channel of an AC'97-style audio link controller. The host loads 32-bit words into a small sample queue through a register write port. The frame serializer is modelled as a strobe, `slot_req`, that carries the slot number it is about to fill. When the channel is enabled and owns that slot, it returns one 20-bit, MSB-justified sample in the following cycle.

The control register has several settings. A per-slot ownership mask maps the stream onto any subset of slots 1 to 12. A sample-width code selects 16, 18, 20 or 12 bits. A packed mode places two 16-bit samples in each host word. A queue-enable bit switches between the full queue and a single holding word.

The status register reports empty, half-empty, full, busy and underrun. Three interrupt sources share one `irq` line, each with its own enable: queue level, transmit complete and underrun. The complete and underrun sources are sticky and are cleared by the host.

The channel owns no timing of its own. Samples are handed out in the order the slots are requested, so a serializer that walks a frame in ascending slot order receives the queue contents in ascending slot order. Dropping the interface enable empties the queue and clears the half-word position. All register settings are kept.

Top module: `ac97_tx_channel`

## Requirements
- R1: After reset, the control, interrupt-enable and sticky flags are zero, the queue is empty, status reads 0x0000000A and interrupt status reads 0x00000004. `irq` is low and `samp_valid` is low.
- R2: A write to address 5 (data) with `iface_en` high appends the word unless the queue is full. Full means the count has reached the capacity: DEPTH when control bit 16 is set, and 1 word when it is clear. A write to a full queue is discarded and leaves the contents unchanged.
- R3: A `slot_req` for slot n (1..12) gives `samp_valid` high for exactly the next cycle only if control bit 0 (transmit enable) and control bit n (slot n owned) are both set. Any other request gives no sample.
- R4: When control bit 15 is clear, the head word is consumed whole. Control bits 14:13 select its width: 00 gives 16 bits, 01 gives 18, 10 gives 20 and 11 gives 12. The low bits of that width are placed at the top of the 20-bit `samp_data`, with zeros below.
- R5: When control bit 15 (packed mode) is set, the bits 15:0 of a word are sent first, each as a 16-bit sample shifted up by 4 bits. Bits 31:16 are sent on the next owned request. The word leaves the queue only after its second half is sent.
- R6: Samples leave the queue strictly in request order. Slots that are not owned take nothing, so with slots 3, 4, 6, 7, 8 and 9 owned, one ascending frame delivers six consecutive words to those slots in that order.
- R7: An owned request while the queue is empty sends a zero sample. It also sets a sticky underrun flag, seen at status bit 9 and interrupt status bit 5. Writing 1 to bit 5 of address 4 (clear) clears the flag, and a new underrun in the same cycle takes priority over the clear.
- R8: Status (address 1) has five bits. Bit 1 is queue empty. Bit 3 is half-empty, meaning 2·count ≤ capacity. Bit 5 is full. Bit 7 is busy, meaning the queue holds data or a sample is in its output cycle. Bit 9 is underrun.
- R9: The cycle after busy falls while `iface_en` is high, interrupt status bit 0 (transmit complete) becomes set and stays set. Writing 1 to bit 0 of address 4 clears it.
- R10: Interrupt status (address 2) bit 2 follows the half-empty level. Address 3 holds enables at bit positions 0, 2 and 5, and `irq` is the OR of the enabled interrupt status bits.
- R11: Clearing control bit 0 keeps the queued words for later requests. While `iface_en` is low, the queue is emptied, data writes are ignored and the control setting is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iface_en | input | 1 | Link interface enable; low flushes the queue |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address: 0 control, 3 int enable, 4 clear, 5 data |
| reg_wdata | input | 32 | Write data |
| rd_addr | input | 3 | Read address: 0 control, 1 status, 2 int status, 3 int enable |
| rd_data | output | 32 | Combinational read data |
| slot_req | input | 1 | Serializer requests a sample for `slot_idx` |
| slot_idx | input | 4 | Slot number of the request |
| samp_valid | output | 1 | A sample is presented this cycle |
| samp_data | output | 20 | MSB-justified sample |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The assertions take for granted that the serializer raises `slot_req` for at most one slot per cycle. They also assume `iface_en` is a level that the host holds across register writes, not a pulse that races a data write. The stimulus drives every input once per cycle on the falling edge and keeps to one request per strobe. It lowers `iface_en` only between register writes, so every push, pop and flush falls on a well-defined rising edge.

// File: rtl/ac97_txch_pkg.sv
package ac97_txch_pkg;

  localparam int SAMP_W = 20;
  localparam int WORD_W = 32;
  localparam int CTRL_W = 17;
  localparam int IRQ_W  = 7;

  // register addresses
  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_STAT  = 3'd1;
  localparam logic [2:0] RA_ISTAT = 3'd2;
  localparam logic [2:0] RA_IEN   = 3'd3;
  localparam logic [2:0] RA_CLR   = 3'd4;
  localparam logic [2:0] RA_DATA  = 3'd5;

  // status bit positions
  localparam int SB_EMPTY = 1;
  localparam int SB_HALF  = 3;
  localparam int SB_FULL  = 5;
  localparam int SB_BUSY  = 7;
  localparam int SB_UNDER = 9;

  // interrupt bit positions (status and enable share them)
  localparam int IB_DONE  = 0;
  localparam int IB_LEVEL = 2;
  localparam int IB_UNDER = 5;

  typedef enum logic [1:0] {
    SZ16 = 2'b00,
    SZ18 = 2'b01,
    SZ20 = 2'b10,
    SZ12 = 2'b11
  } samp_size_e;

  // packed so that bit positions match the control register
  typedef struct packed {
    logic        fen;       // 16
    logic        packed2;   // 15
    samp_size_e  size;      // 14:13
    logic [12:1] slot_en;   // 12:1
    logic        tx_en;     // 0
  } ctrl_t;

  // turn a queue word into a 20-bit MSB-justified slot sample
  function automatic logic [SAMP_W-1:0] fmt_word(input logic [WORD_W-1:0] w,
                                                 input samp_size_e sz,
                                                 input logic packed2,
                                                 input logic upper);
    logic [SAMP_W-1:0] r;
    if (packed2) begin
      r = upper ? {w[31:16], 4'h0} : {w[15:0], 4'h0};
    end else begin
      case (sz)
        SZ16:    r = {w[15:0], 4'h0};
        SZ18:    r = {w[17:0], 2'b00};
        SZ20:    r = w[19:0];
        default: r = {w[11:0], 8'h00};
      endcase
    end
    return r;
  endfunction

  // half-empty: occupancy no more than half the capacity
  function automatic logic half_empty(input logic [15:0] cnt, input logic [15:0] lim);
    return ({cnt, 1'b0}) <= {1'b0, lim};
  endfunction

endpackage

// File: rtl/txch_fifo.sv
module txch_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DW-1:0]                wdata,
  input  logic [$clog2(DEPTH+1)-1:0]   lim,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full,
  output logic                         acc_push,
  output logic                         acc_pop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (cnt == '0);
  assign full     = (cnt >= lim);
  assign acc_push = push & ~full & ~flush;
  assign acc_pop  = pop & ~empty & ~flush;
  assign rdata    = mem[rp];
  assign count    = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (acc_push) wp <= nxt(wp);
      if (acc_pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(acc_push) - CW'(acc_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (acc_push) mem[wp] <= wdata;
  end

endmodule

// File: rtl/txch_regs.sv
module txch_regs
  import ac97_txch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              done_set,
  input  logic              under_set,
  output ctrl_t             ctrl,
  output logic [IRQ_W-1:0]  ien,
  output logic              done_flag,
  output logic              under_flag,
  output logic              clr_done,
  output logic              clr_under
);
  assign clr_done  = wr & (addr == RA_CLR) & wdata[IB_DONE];
  assign clr_under = wr & (addr == RA_CLR) & wdata[IB_UNDER];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl       <= '0;
      ien        <= '0;
      done_flag  <= 1'b0;
      under_flag <= 1'b0;
    end else begin
      if (wr && addr == RA_CTRL) ctrl <= ctrl_t'(wdata);
      if (wr && addr == RA_IEN) begin
        ien           <= '0;
        ien[IB_DONE]  <= wdata[IB_DONE];
        ien[IB_LEVEL] <= wdata[IB_LEVEL];
        ien[IB_UNDER] <= wdata[IB_UNDER];
      end
      done_flag  <= done_set  | (done_flag  & ~clr_done);
      under_flag <= under_set | (under_flag & ~clr_under);
    end
  end

endmodule

// File: rtl/txch_feed.sv
module txch_feed
  import ac97_txch_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iface_en,
  input  ctrl_t              ctrl,
  input  logic               slot_req,
  input  logic [3:0]         slot_idx,
  input  logic               q_empty,
  input  logic [WORD_W-1:0]  q_head,
  output logic               pop,
  output logic               under_evt,
  output logic               samp_valid,
  output logic [SAMP_W-1:0]  samp_data
);
  logic slot_on, serve, take, upper;

  always_comb begin
    slot_on = 1'b0;
    for (int i = 1; i <= 12; i++) begin
      if (slot_idx == 4'(i)) slot_on = ctrl.slot_en[i];
    end
  end

  assign serve     = iface_en & slot_req & ctrl.tx_en & slot_on;
  assign under_evt = serve & q_empty;
  assign take      = serve & ~q_empty;
  assign pop       = take & (~ctrl.packed2 | upper);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper      <= 1'b0;
      samp_valid <= 1'b0;
      samp_data  <= '0;
    end else begin
      if (!iface_en)  upper <= 1'b0;
      else if (take)  upper <= ctrl.packed2 & ~upper;
      samp_valid <= serve;
      samp_data  <= take ? fmt_word(q_head, ctrl.size, ctrl.packed2, upper) : '0;
    end
  end

endmodule

// File: rtl/ac97_tx_channel.sv
module ac97_tx_channel
  import ac97_txch_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iface_en,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic [2:0]         rd_addr,
  output logic [31:0]        rd_data,
  input  logic               slot_req,
  input  logic [3:0]         slot_idx,
  output logic               samp_valid,
  output logic [SAMP_W-1:0]  samp_data,
  output logic               irq
);
  localparam int CW = $clog2(DEPTH+1);

  ctrl_t              ctrl;
  logic [IRQ_W-1:0]   ien, istat;
  logic               done_flag, under_flag, clr_done, clr_under;
  logic               push, pop, under_evt, flush;
  logic               q_empty, q_full, acc_push, acc_pop;
  logic [CW-1:0]      q_count, lim;
  logic [WORD_W-1:0]  q_head;
  logic               busy, busy_q, busy_fell, done_set, lvl_half;
  logic [31:0]        stat;

  assign flush = ~iface_en;
  assign push  = reg_wr & (reg_addr == RA_DATA) & iface_en;
  assign lim   = ctrl.fen ? CW'(DEPTH) : CW'(1);

  txch_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata[CTRL_W-1:0]), .done_set(done_set), .under_set(under_evt),
    .ctrl(ctrl), .ien(ien), .done_flag(done_flag), .under_flag(under_flag),
    .clr_done(clr_done), .clr_under(clr_under)
  );

  txch_fifo #(.DEPTH(DEPTH), .DW(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
    .wdata(reg_wdata), .lim(lim), .rdata(q_head), .count(q_count),
    .empty(q_empty), .full(q_full), .acc_push(acc_push), .acc_pop(acc_pop)
  );

  txch_feed u_feed (
    .clk(clk), .rst_n(rst_n), .iface_en(iface_en), .ctrl(ctrl),
    .slot_req(slot_req), .slot_idx(slot_idx), .q_empty(q_empty),
    .q_head(q_head), .pop(pop), .under_evt(under_evt),
    .samp_valid(samp_valid), .samp_data(samp_data)
  );

  // busy tracking and transmit-complete detection
  assign busy      = ~q_empty | samp_valid;
  assign busy_fell = busy_q & ~busy;
  assign done_set  = busy_fell & iface_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy;
  end

  assign lvl_half = half_empty(16'(q_count), 16'(lim));

  always_comb begin
    stat           = '0;
    stat[SB_EMPTY] = q_empty;
    stat[SB_HALF]  = lvl_half;
    stat[SB_FULL]  = q_full;
    stat[SB_BUSY]  = busy;
    stat[SB_UNDER] = under_flag;
    istat           = '0;
    istat[IB_DONE]  = done_flag;
    istat[IB_LEVEL] = lvl_half;
    istat[IB_UNDER] = under_flag;
  end

  always_comb begin
    case (rd_addr)
      RA_CTRL:  rd_data = {{(32-CTRL_W){1'b0}}, ctrl};
      RA_STAT:  rd_data = stat;
      RA_ISTAT: rd_data = {{(32-IRQ_W){1'b0}}, istat};
      RA_IEN:   rd_data = {{(32-IRQ_W){1'b0}}, ien};
      default:  rd_data = '0;
    endcase
  end

  assign irq = |(istat & ien);

endmodule

// File: rtl/ac97_tx_channel_chk.sv
module ac97_tx_channel_chk #(
  parameter int DEPTH = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        iface_en,
  input logic                        slot_req,
  input logic                        tx_en,
  input logic                        samp_valid,
  input logic [19:0]                 samp_data,
  input logic [$clog2(DEPTH+1)-1:0]  q_count,
  input logic                        q_full,
  input logic                        push,
  input logic                        acc_pop,
  input logic                        under_evt,
  input logic                        under_flag,
  input logic                        clr_under,
  input logic                        busy,
  input logic                        done_flag
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= ($clog2(DEPTH+1))'(DEPTH)); // R2

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push && q_full && !acc_pop |=> $stable(q_count)); // R2

  AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && !tx_en |=> !samp_valid); // R3

  AST_UNDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    under_evt |=> samp_valid && samp_data == 20'h0); // R7

  AST_UNDER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    under_flag && !clr_under |=> under_flag); // R7

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && iface_en |=> done_flag); // R9

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !iface_en |=> q_count == '0); // R11

endmodule

bind ac97_tx_channel ac97_tx_channel_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .iface_en(iface_en), .slot_req(slot_req),
  .tx_en(ctrl.tx_en), .samp_valid(samp_valid), .samp_data(samp_data),
  .q_count(q_count), .q_full(q_full), .push(push), .acc_pop(acc_pop),
  .under_evt(under_evt), .under_flag(under_flag), .clr_under(clr_under),
  .busy(busy), .done_flag(done_flag)
);

// File: tb/ac97_tx_channel_tb.sv
`timescale 1ns/100ps
module ac97_tx_channel_tb;
  localparam int DEPTH = 8;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_IST = 3'd2,
                         A_IEN = 3'd3, A_CLR = 3'd4, A_DATA = 3'd5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, iface_en = 1'b1, reg_wr = 1'b0, slot_req = 1'b0;
  logic [2:0]  reg_addr = '0, rd_addr = '0;
  logic [31:0] reg_wdata = '0, rd_data;
  logic [3:0]  slot_idx = '0;
  logic        samp_valid, irq;
  logic [19:0] samp_data;

  ac97_tx_channel #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .iface_en(iface_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .slot_req(slot_req), .slot_idx(slot_idx),
    .samp_valid(samp_valid), .samp_data(samp_data), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] q[$];
  logic [16:0] m_ctrl;
  logic [6:0]  m_ien;
  bit          m_done, m_under, m_upper, m_sv, m_busyq;
  logic [19:0] m_sd;

  function automatic int m_cap();
    return m_ctrl[16] ? DEPTH : 1;
  endfunction

  function automatic bit m_busy();
    return (q.size() != 0) || m_sv;
  endfunction

  function automatic bit m_half();
    return 2 * q.size() <= m_cap();
  endfunction

  function automatic logic [19:0] m_fmt(input logic [31:0] w, input bit up);
    int width;
    logic [31:0] v;
    if (m_ctrl[15]) return 20'((up ? (w >> 16) : w) & 32'hFFFF) << 4;
    case (m_ctrl[14:13])
      2'd0: width = 16;
      2'd1: width = 18;
      2'd2: width = 20;
      default: width = 12;
    endcase
    v = w & ((32'h1 << width) - 1);
    return 20'(v << (20 - width));
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    logic [31:0] r = 0;
    case (a)
      A_CTRL: r = {15'b0, m_ctrl};
      A_STAT: begin
        r[1] = (q.size() == 0); r[3] = m_half(); r[5] = (q.size() >= m_cap());
        r[7] = m_busy(); r[9] = m_under;
      end
      A_IST: begin r[0] = m_done; r[2] = m_half(); r[5] = m_under; end
      A_IEN: r = {25'b0, m_ien};
      default: r = 0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    int cnt;
    bit bnow, dset, serve, uset, dopop, pushok;
    logic [19:0] nd;
    if (!rst_n) begin
      q.delete(); m_ctrl = 0; m_ien = 0; m_done = 0; m_under = 0;
      m_upper = 0; m_sv = 0; m_busyq = 0; m_sd = 0;
    end else begin
      cnt = q.size();
      bnow = (cnt != 0) || m_sv;
      dset = iface_en && m_busyq && !bnow;
      m_busyq = bnow;
      serve = iface_en && slot_req && m_ctrl[0] && slot_idx >= 1 && slot_idx <= 12
              && m_ctrl[slot_idx];
      nd = 0; uset = 0; dopop = 0;
      if (serve) begin
        if (cnt == 0) uset = 1;
        else begin
          nd = m_fmt(q[0], m_upper);
          if (m_ctrl[15]) begin dopop = m_upper; m_upper = !m_upper; end
          else begin dopop = 1; m_upper = 0; end
        end
      end
      pushok = iface_en && reg_wr && reg_addr == A_DATA && cnt < m_cap();
      if (dopop) void'(q.pop_front());
      if (pushok) q.push_back(reg_wdata);
      if (reg_wr && reg_addr == A_CTRL) m_ctrl = reg_wdata[16:0];
      if (reg_wr && reg_addr == A_IEN) m_ien = reg_wdata[6:0] & 7'h25;
      m_done  = dset || (m_done && !(reg_wr && reg_addr == A_CLR && reg_wdata[0]));
      m_under = uset || (m_under && !(reg_wr && reg_addr == A_CLR && reg_wdata[5]));
      if (!iface_en) begin q.delete(); m_upper = 0; end
      m_sv = serve; m_sd = nd;
    end
  end

  // per-cycle comparison, away from both edges
  always @(negedge clk) begin
    if (rst_n) begin
      #2;
      expect32("R3 samp_valid", {31'b0, samp_valid}, {31'b0, m_sv});
      if (m_sv) expect32("R4 samp_data", {12'b0, samp_data}, {12'b0, m_sd});
      expect32("R10 irq", {31'b0, irq}, {31'b0, |(m_read(A_IST)[6:0] & m_ien)});
      expect32("R8 rd_data", rd_data, m_read(rd_addr));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a; #1; v = rd_data;
  endtask

  task automatic req(input int s, output logic v, output logic [19:0] d);
    @(negedge clk); slot_req = 1'b1; slot_idx = 4'(s);
    @(negedge clk); slot_req = 1'b0; v = samp_valid; d = samp_data;
  endtask

  task automatic req_chk(input string tag, input int s, input logic ev, input logic [19:0] ed);
    logic v; logic [19:0] d;
    req(s, v, d);
    expect32({tag, " valid"}, {31'b0, v}, {31'b0, ev});
    if (ev) expect32({tag, " data"}, {12'b0, d}, {12'b0, ed});
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_CTRL, v); expect32("R1 ctrl", v, 32'h0);
    rd(A_STAT, v); expect32("R1 stat", v, 32'h0000000A);
    rd(A_IST, v);  expect32("R1 istat", v, 32'h00000004);
    expect32("R1 irq", {31'b0, irq}, 32'h0);
    expect32("R1 samp_valid", {31'b0, samp_valid}, 32'h0);

    // R3 / R4 / R8 basic two-slot stream, 16-bit
    wr(A_CTRL, 32'h0001_0019);
    wr(A_DATA, 32'h0000_1234);
    wr(A_DATA, 32'h0000_5678);
    rd(A_STAT, v); expect32("R8 stat two words", v, 32'h0000_0088);
    req_chk("R4 slot3 16b", 3, 1'b1, 20'h12340);
    req_chk("R3 unowned slot5", 5, 1'b0, 20'h0);
    req_chk("R3 slot4", 4, 1'b1, 20'h56780);

    // R7 underrun
    req_chk("R7 zero sample", 3, 1'b1, 20'h0);
    rd(A_STAT, v); expect32("R7 stat bit9", v & 32'h200, 32'h200);
    rd(A_IST, v);  expect32("R7 istat bit5", v & 32'h20, 32'h20);
    wr(A_CLR, 32'h20);
    rd(A_IST, v);  expect32("R7 cleared", v & 32'h20, 32'h0);

    // R9 transmit complete
    wr(A_CLR, 32'h01);
    rd(A_IST, v);  expect32("R9 cleared", v & 32'h1, 32'h0);
    wr(A_DATA, 32'h0000_AAAA);
    req_chk("R9 last word", 3, 1'b1, 20'hAAAA0);
    repeat (3) @(negedge clk);
    rd(A_IST, v);  expect32("R9 complete set", v & 32'h1, 32'h1);

    // R10 interrupt enables
    wr(A_IEN, 32'h04); #1; expect32("R10 level irq", {31'b0, irq}, 32'h1);
    wr(A_IEN, 32'h01); #1; expect32("R10 done irq", {31'b0, irq}, 32'h1);
    wr(A_CLR, 32'h01); #1; expect32("R10 irq cleared", {31'b0, irq}, 32'h0);
    wr(A_IEN, 32'h00);

    // R4 widths
    wr(A_CTRL, 32'h0001_2019); wr(A_DATA, 32'h0002_5555);
    req_chk("R4 18-bit", 3, 1'b1, 20'h95554);
    wr(A_CTRL, 32'h0001_4019); wr(A_DATA, 32'h00FA_BCDE);
    req_chk("R4 20-bit", 3, 1'b1, 20'hABCDE);
    wr(A_CTRL, 32'h0001_6019); wr(A_DATA, 32'h0000_0ABC);
    req_chk("R4 12-bit", 3, 1'b1, 20'hABC00);

    // R5 packed mode
    wr(A_CTRL, 32'h0001_8019);
    wr(A_DATA, 32'h1111_2222); wr(A_DATA, 32'h3333_4444);
    req_chk("R5 w0 low", 3, 1'b1, 20'h22220);
    rd(A_STAT, v); expect32("R5 word kept", v & 32'h2, 32'h0);
    req_chk("R5 w0 high", 4, 1'b1, 20'h11110);
    req_chk("R5 w1 low", 3, 1'b1, 20'h44440);
    req_chk("R5 w1 high", 4, 1'b1, 20'h33330);

    // R6 six-slot ascending frame
    wr(A_CTRL, 32'h0001_03D9);
    for (int k = 1; k <= 6; k++) wr(A_DATA, 32'(k));
    begin
      int nxt = 1;
      for (int s = 3; s <= 9; s++) begin
        if (s == 5) req_chk("R6 skip slot5", s, 1'b0, 20'h0);
        else begin req_chk("R6 ascending", s, 1'b1, 20'(nxt << 4)); nxt++; end
      end
    end
    wr(A_CLR, 32'h21);

    // R2 full with queue enabled
    wr(A_CTRL, 32'h0001_0019);
    for (int k = 1; k <= 9; k++) wr(A_DATA, 32'(k));
    rd(A_STAT, v); expect32("R2 full stat", v, 32'h0000_00A0);
    for (int k = 1; k <= 8; k++) req_chk("R2 drain", 3, 1'b1, 20'(k << 4));
    req_chk("R2 ninth dropped", 3, 1'b1, 20'h0);
    wr(A_CLR, 32'h21);
    // R2 single holding word
    wr(A_CTRL, 32'h0000_0019);
    wr(A_DATA, 32'h77); wr(A_DATA, 32'h88);
    rd(A_STAT, v); expect32("R2 one-word full", v, 32'h0000_00A0);
    req_chk("R2 held word", 3, 1'b1, 20'h00770);
    req_chk("R2 second dropped", 3, 1'b1, 20'h0);
    wr(A_CLR, 32'h21);

    // R11 disable keeps data, interface-off flushes
    wr(A_CTRL, 32'h0001_0019);
    wr(A_DATA, 32'h1); wr(A_DATA, 32'h2);
    wr(A_CTRL, 32'h0001_0018);
    req_chk("R11 tx off silent", 3, 1'b0, 20'h0);
    rd(A_STAT, v); expect32("R11 data kept", v & 32'h2, 32'h0);
    wr(A_CTRL, 32'h0001_0019);
    req_chk("R11 resumes", 3, 1'b1, 20'h00010);
    @(negedge clk); iface_en = 1'b0;
    wr(A_DATA, 32'h99);
    rd(A_STAT, v); expect32("R11 flushed", v & 32'h2, 32'h2);
    rd(A_CTRL, v); expect32("R11 ctrl kept", v, 32'h0001_0019);
    @(negedge clk); iface_en = 1'b1;
    rd(A_STAT, v); expect32("R11 still empty", v & 32'h2, 32'h2);
    req_chk("R11 nothing left", 3, 1'b1, 20'h0);
    wr(A_CLR, 32'h21);
    repeat (4) @(negedge clk);
    summary();
  end

endmodule